// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer with an 8-bit up-counter, a control register and a reset status register, reached through a small register bus. The bus has an address, a 16-bit write data word, two byte strobes, a read strobe and an 8-bit read data output. The counter and the control register are loaded through one shared write address. The upper byte of the written word is a key that picks the target register, and the lower byte is the value loaded into it. A write is accepted only when both byte strobes are set and the key is one of the two valid codes. Anything else leaves the registers alone.

While the enable bit is set, each tick input pulse advances the counter. If the counter wraps from its all-ones value while the mode bit selects watchdog operation, the block does two things:
- It drives a chip-wide reset pulse of fixed length.
- It latches a sticky flag in the reset status register.

Software can clear that flag only in two steps. It must first read the status register while the flag is 1, and then write 0 to the flag. Asserting the external reset pin also clears the flag.

Top module: `wdt_guard`

## Requirements
- R1: A write to address 0 with both byte strobes set (`bus_be_i` = 2'b11) and upper byte 0x5A loads the lower byte into the counter. The counter reads back at address 1.
- R2: A write to address 0 with both byte strobes set and upper byte 0xA5 loads the lower byte into the control register. The control register reads back at address 0. Control bit 5 is the count enable and bit 6 selects watchdog mode (1) over interval mode (0).
- R3: A full-word write to address 0 with any other upper byte changes neither the counter nor the control register.
- R4: A write to address 0 with only one byte strobe set is ignored, whatever the key.
- R5: With the enable bit set, each cycle with `tick_i` high adds one to the counter. With the enable bit clear, ticks have no effect. In interval mode the counter wraps from 0xFF to 0x00 with no reset and no flag.
- R6: A tick that wraps the counter in watchdog mode does two things. It drives `chip_rst_o` high for exactly PULSE_LEN (default 8) cycles, starting the cycle after the tick. It sets the flag, which is bit 7 of the status register at address 2. The counter reads 0 once the pulse has ended.
- R7: A write at address 2 with `bus_be_i[0]` set and data bit 7 equal to 0 clears the flag only if a read of address 2 returned the flag as 1 earlier. Without that read, the flag stays set.
- R8: A write at address 2 that is not a clear (data bit 7 = 1) cancels a pending read-armed clear. A later 0 write then leaves the flag set.
- R9: A read of address 2 returns bits 5:0 as all ones and bit 6 as 0.
- R10: Asserting `rst_n` clears the flag, the counter and the control register, and ends any reset pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous assert |
| tick_i | input | 1 | Count tick, one cycle per increment |
| bus_addr_i | input | ADDR_W | Register address (0 shared write/control, 1 counter, 2 status) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms the flag clear when reading address 2) |
| bus_be_i | input | 2 | Byte strobes: bit 1 upper byte, bit 0 lower byte |
| bus_wdata_i | input | DATA_W | Write word: key in upper byte, value in lower byte |
| bus_rdata_o | output | DATA_W/2 | Read data for the addressed register |
| chip_rst_o | output | 1 | Chip reset pulse raised by a watchdog-mode overflow |

## Verification
The checker tests on every cycle the properties that hold locally in time:
- A bad key or a byte-only write to the shared address leaves the counter and control register unchanged.
- A set flag cannot drop without an armed clear.
- A watchdog-mode wrap raises the reset output and the flag one cycle later.
- The counter is 0 when the pulse falls.
- The fixed status bits read back correctly.

Some behaviour spans several transactions and only the bench scenarios can show it: the exact pulse length, the read-then-write clear, its cancellation by an intervening non-clear write, and the pin clearing the flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned KEY_BITS = 8;
  localparam logic [KEY_BITS-1:0] KEY_LOAD_CNT  = 8'h5A;
  localparam logic [KEY_BITS-1:0] KEY_LOAD_CTRL = 8'hA5;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CNT   = 2'd1,
    SEL_RSTAT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cnt_load_o,
  output logic              ctrl_load_o,
  output logic              rstat_wr_o,
  output logic [DATA_W/2-1:0] payload_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] key;
  logic              shared_hit;

  always_comb begin
    key         = wdata_i[DATA_W-1:HALF_W];
    payload_o   = wdata_i[HALF_W-1:0];
    // only whole-word writes to the shared address count
    shared_hit  = wr_i && (addr_i == ADDR_W'(SEL_CTRL)) && (&be_i);
    cnt_load_o  = shared_hit && (key == HALF_W'(KEY_LOAD_CNT));
    ctrl_load_o = shared_hit && (key == HALF_W'(KEY_LOAD_CTRL));
    rstat_wr_o  = wr_i && (addr_i == ADDR_W'(SEL_RSTAT)) && be_i[0];
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wdmode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trip_o,
  output logic             pulse_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    pls_q, pls_d;
  logic             busy, wrap, cnt_en, pls_en;

  always_comb begin
    busy   = (pls_q != '0);
    wrap   = !busy && !load_i && tick_i && en_i && (cnt_q == '1);
    trip_o = wrap && wdmode_i;

    cnt_en = busy || load_i || (tick_i && en_i);
    if (busy)        cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else             cnt_d = cnt_q + 1'b1;

    pls_en = trip_o || busy;
    if (trip_o) pls_d = PW'(PULSE_LEN);
    else        pls_d = pls_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (pls_en) pls_q <= pls_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = busy;
endmodule

// File: rtl/wdt_rstflag.sv
module wdt_rstflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d, armed_q, armed_d, do_clr;

  always_comb begin
    do_clr = wr_hit_i && armed_q && !wbit_i;
    flag_d = flag_q;
    if (set_i)       flag_d = 1'b1;
    else if (do_clr) flag_d = 1'b0;

    armed_d = armed_q;
    if (wr_hit_i)                armed_d = 1'b0;
    else if (rd_hit_i && flag_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PULSE_LEN = 8,
  parameter int unsigned EN_BIT    = 5,
  parameter int unsigned MODE_BIT  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [1:0]            bus_be_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W/2-1:0]   bus_rdata_o,
  output logic                  chip_rst_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              cnt_load, ctrl_load, rstat_wr, trip, rd_hit;
  logic [HALF_W-1:0] payload;
  logic [HALF_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q, armed_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wdt_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .be_i        (bus_be_i),
    .wdata_i     (bus_wdata_i),
    .cnt_load_o  (cnt_load),
    .ctrl_load_o (ctrl_load),
    .rstat_wr_o  (rstat_wr),
    .payload_o   (payload)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)     ctrl_q <= '0;
    else if (ctrl_load) ctrl_q <= payload;
  end

  wdt_counter #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_i     (tick_i),
    .en_i       (ctrl_q[EN_BIT]),
    .wdmode_i   (ctrl_q[MODE_BIT]),
    .load_i     (cnt_load),
    .load_val_i (payload[CNT_W-1:0]),
    .cnt_o      (cnt_q),
    .trip_o     (trip),
    .pulse_o    (chip_rst_o)
  );

  assign rd_hit = bus_rd_i && (bus_addr_i == ADDR_W'(SEL_RSTAT));

  wdt_rstflag u_flag (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_i    (trip),
    .rd_hit_i (rd_hit),
    .wr_hit_i (rstat_wr),
    .wbit_i   (payload[HALF_W-1]),
    .flag_o   (flag_q),
    .armed_o  (armed_q)
  );

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(SEL_CTRL):  bus_rdata_o = ctrl_q;
      ADDR_W'(SEL_CNT):   bus_rdata_o = HALF_W'(cnt_q);
      ADDR_W'(SEL_RSTAT): bus_rdata_o = {flag_q, 1'b0, {(HALF_W-2){1'b1}}};
      default:            bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned EN_BIT   = 5,
  parameter int unsigned MODE_BIT = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_i,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [1:0]          bus_be_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [DATA_W/2-1:0] bus_rdata_o,
  input logic                chip_rst_o,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [DATA_W/2-1:0] ctrl_q,
  input logic                flag_q,
  input logic                armed_q
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] key;
  logic              shared_wr, is_clear;
  assign key       = bus_wdata_i[DATA_W-1:HALF_W];
  assign shared_wr = bus_wr_i && (bus_addr_i == '0);
  assign is_clear  = bus_wr_i && (bus_addr_i == ADDR_W'(2)) && bus_be_i[0]
                     && !bus_wdata_i[HALF_W-1];

  assert_badkey_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shared_wr && (&bus_be_i) && !tick_i && (key != HALF_W'(8'h5A)) && (key != HALF_W'(8'hA5))
    |=> $stable(cnt_q) && $stable(ctrl_q));

  assert_bytewr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shared_wr && !(&bus_be_i) |=> $stable(ctrl_q));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(is_clear && armed_q) |=> flag_q);

  assert_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && ctrl_q[EN_BIT] && ctrl_q[MODE_BIT] && (cnt_q == '1) && !chip_rst_o
    && !(shared_wr && (&bus_be_i) && (key == HALF_W'(8'h5A)))
    |=> chip_rst_o && flag_q);

  assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst_o) |-> (cnt_q == '0));

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(2)) |-> (bus_rdata_o[HALF_W-3:0] == '1) && !bus_rdata_o[HALF_W-2]);
endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT), .MODE_BIT(MODE_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .tick_i      (tick_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .chip_rst_o  (chip_rst_o),
  .cnt_q       (cnt_q),
  .ctrl_q      (ctrl_q),
  .flag_q      (flag_q),
  .armed_q     (armed_q)
);

// File: tb/test_wdt_guard.sv
`timescale 1ns/1ps
module test_wdt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        chip_rst;
  logic        probe = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_rst;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .chip_rst_o(chip_rst)
  );

  // monitor: pops the expected item and compares it with the port value
  always @(negedge clk) begin
    #1;
    if (probe && sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = it.is_rst ? {7'b0, chip_rst} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  // driver tasks: entered just after a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [1:0] b, input logic [15:0] d);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_rst = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    addr = a; rd = 1'b1; probe = 1'b1;
    @(negedge clk);
    rd = 1'b0; probe = 1'b0;
  endtask

  task automatic expect_rst(input logic e, input string tag);
    item_t it;
    it.is_rst = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    sb.push_back(it);
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
  endtask

  task automatic pin_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic trip_watchdog();
    bus_write(2'd0, 2'b11, 16'hA560);
    bus_write(2'd0, 2'b11, 16'h5AFF);
    ticks(1);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    pin_reset();
    // R10 / R9: reset values
    expect_reg(2'd0, 8'h00, "R10 ctrl after reset");
    expect_reg(2'd1, 8'h00, "R10 counter after reset");
    expect_reg(2'd2, 8'h3F, "R9 status after reset");
    expect_rst(1'b0, "R10 no chip reset");

    // R1 / R2: keyed loads
    bus_write(2'd0, 2'b11, 16'h5A37);
    expect_reg(2'd1, 8'h37, "R1 counter load");
    bus_write(2'd0, 2'b11, 16'hA520);
    expect_reg(2'd0, 8'h20, "R2 ctrl load");

    // R3: bad keys
    bus_write(2'd0, 2'b11, 16'h3399);
    bus_write(2'd0, 2'b11, 16'h5BFF);
    expect_reg(2'd0, 8'h20, "R3 ctrl unchanged");
    expect_reg(2'd1, 8'h37, "R3 counter unchanged");

    // R4: byte writes
    bus_write(2'd0, 2'b01, 16'h5A10);
    bus_write(2'd0, 2'b10, 16'h5A11);
    bus_write(2'd0, 2'b01, 16'hA500);
    expect_reg(2'd1, 8'h37, "R4 counter unchanged");
    expect_reg(2'd0, 8'h20, "R4 ctrl unchanged");

    // R5: counting, disable, interval wrap
    ticks(3);
    expect_reg(2'd1, 8'h3A, "R5 three ticks");
    bus_write(2'd0, 2'b11, 16'hA500);
    ticks(2);
    expect_reg(2'd1, 8'h3A, "R5 disabled ticks");
    bus_write(2'd0, 2'b11, 16'hA520);
    bus_write(2'd0, 2'b11, 16'h5AFE);
    ticks(2);
    expect_reg(2'd1, 8'h00, "R5 interval wrap");
    expect_rst(1'b0, "R5 no reset in interval mode");
    expect_reg(2'd2, 8'h3F, "R5 no flag in interval mode");

    // R6: watchdog overflow pulse
    bus_write(2'd0, 2'b11, 16'hA560);
    bus_write(2'd0, 2'b11, 16'h5AFF);
    ticks(1);
    expect_rst(1'b1, "R6 pulse first cycle");
    repeat (6) @(negedge clk);
    expect_rst(1'b1, "R6 pulse last cycle");
    expect_rst(1'b0, "R6 pulse ended");
    expect_reg(2'd1, 8'h00, "R6 counter after pulse");

    // R7: clear needs prior read
    bus_write(2'd2, 2'b11, 16'h0000);
    expect_reg(2'd2, 8'hBF, "R7 flag kept without read");
    bus_write(2'd2, 2'b11, 16'h0000);
    expect_reg(2'd2, 8'h3F, "R7 flag cleared after read");

    // R8: intervening non-clear write cancels the arm
    trip_watchdog();
    expect_reg(2'd2, 8'hBF, "R8 flag set again");
    bus_write(2'd2, 2'b01, 16'h0080);
    bus_write(2'd2, 2'b01, 16'h0000);
    expect_reg(2'd2, 8'hBF, "R8 arm cancelled");
    bus_write(2'd2, 2'b01, 16'h0000);
    expect_reg(2'd2, 8'h3F, "R8 clear after fresh read");

    // R10: pin clears flag and registers
    trip_watchdog();
    pin_reset();
    expect_reg(2'd2, 8'h3F, "R10 flag cleared by pin");
    expect_reg(2'd0, 8'h00, "R10 ctrl cleared by pin");
    expect_reg(2'd1, 8'h00, "R10 counter cleared by pin");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule